// File: doc/BRIEF.md
# Programmable LCD Timing Controller

This block produces the horizontal and vertical timing for a display panel. A 12-bit horizontal counter runs once per pixel clock. It is compared each cycle against six programmable thresholds. When the counter equals a threshold, the controller latches into a new line phase, and it stays there until the next match. The phases are sync, back porch, left border, active image, right border and front porch. A vertical counter advances once per line and wraps after a programmable line count.

The outputs follow the phase. They are a horizontal sync pulse, a vertical sync window, a pixel-fetch enable for the active image, a border-select flag and the programmed border color. There are also two interrupt lines, horizontal and vertical, each defined by an assert/deassert compare window and gated by a mask. Software programs the block through a flat 32-bit word-addressed register port with combinational read data. The beam counters can be read back, and pending interrupts are cleared by writing 1.

Top module: `lcd_timing_ctrl`

Register map (word address on `addr_i`):

| Addr | Name | Fields |
|------|------|--------|
| 0 | CTRL | bit 0 run, bit 8 H interrupt mask, bit 9 V interrupt mask (mask 1 = blocked) |
| 1 | STAT | bit 16 H pending, bit 17 V pending, write 1 to clear |
| 2 | H_LAST | last horizontal count of a line |
| 3 | V_LAST | last line number of a frame |
| 4 | H_SYNC_AT | sync event |
| 5 | H_BACK_AT | back porch event |
| 6 | H_LEFT_AT | left border event |
| 7 | H_IMG | bits 11:0 image start, bits 27:16 image end |
| 8 | H_FRONT_AT | front porch event |
| 9 | H_IRQ_WIN | bits 11:0 assert count, bits 27:16 deassert count |
| 10 | V_IRQ_WIN | bits 11:0 assert line, bits 27:16 deassert line |
| 11 | V_SYNC_WIN | bits 11:0 first line, bits 27:16 first line after sync |
| 12 | SYNC_OFF | bit 0 suppress hsync, bit 8 suppress vsync |
| 13 | BORDER_RGB | bits 23:0 color, bits 31:24 ignored |
| 14 | H_NOW | horizontal counter (read only) |
| 15 | V_NOW | vertical counter (read only) |

## Requirements
- R1: While running, the horizontal counter counts 0 to H_LAST and returns to 0 on the next cycle, so a line lasts H_LAST+1 cycles. H_NOW reads the counter.
- R2: When the horizontal counter equals an event threshold, the outputs show the new phase from the following cycle until the next event. hsync_o is high in the sync phase, and pixel-fetch and border outputs are low during sync, back porch and front porch.
- R3: When several thresholds equal the counter in one cycle, the phase taken is the first in this order: sync, back porch, left border, image start, image end, front porch.
- R4: pix_en_o is high only in the image phase (image start event up to image end event). border_sel_o is high in the left border phase (after the left border event) and the right border phase (after image end). border_color_o carries BORDER_RGB bits 23:0 while border_sel_o is high and 0 otherwise, and BORDER_RGB reads back with bits 31:24 as 0.
- R5: The H interrupt window opens the cycle after the counter equals H_IRQ_WIN[11:0] and closes the cycle after it equals H_IRQ_WIN[27:16]. An assert count of H_LAST or more never opens it and never sets H pending.
- R6: The vertical counter advances when the horizontal counter wraps and returns to 0 after V_LAST. V_NOW reads it. vsync_o is high while V_NOW is at least V_SYNC_WIN[11:0] and below V_SYNC_WIN[27:16].
- R7: The V interrupt window is evaluated only while the horizontal counter is 0. It opens on the line V_IRQ_WIN[11:0] and closes on line V_IRQ_WIN[27:16], visible one cycle later. An assert line of V_LAST or more disables it.
- R8: STAT bit 16 (H) and bit 17 (V) set when their window opens, whatever the mask, and clear when 1 is written to them. h_irq_o and v_irq_o follow their window only while the CTRL mask bit (8 or 9) is 0.
- R9: SYNC_OFF bit 0 forces hsync_o low, and bit 8 forces vsync_o low.
- R10: While CTRL bit 0 is 0, both counters are 0 from the next cycle onward, and all timing and interrupt outputs are low.
- R11: After reset, all registers read 0 and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data (combinational on addr_i) |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| pix_en_o | output | 1 | Pixel fetch enable |
| border_sel_o | output | 1 | Border color select |
| border_color_o | output | 24 | Border color during border phases |
| h_irq_o | output | 1 | Masked horizontal interrupt |
| v_irq_o | output | 1 | Masked vertical interrupt |

## Verification
The assertions assume software keeps the counters inside their programmed range. The wrap property depends on the horizontal counter being reset by a count at or beyond H_LAST. The vertical stability property assumes the run bit is not toggled within a line. The bench always programs the full timing set while the run bit is 0, before starting the controller. Later changes touch only thresholds, windows, masks and suppress bits, never the limits. The threshold chain it uses is strictly increasing within one line, except in the deliberate collision test.

// File: rtl/lcd_tc_pkg.sv
package lcd_tc_pkg;
  typedef enum logic [2:0] {
    PH_SYNC  = 3'd0,
    PH_BACK  = 3'd1,
    PH_LEFT  = 3'd2,
    PH_IMAGE = 3'd3,
    PH_RIGHT = 3'd4,
    PH_FRONT = 3'd5
  } phase_e;

  localparam int N_EVT = 6;

  localparam int A_CTRL   = 0;
  localparam int A_STAT   = 1;
  localparam int A_HLAST  = 2;
  localparam int A_VLAST  = 3;
  localparam int A_HSYNC  = 4;
  localparam int A_HBACK  = 5;
  localparam int A_HLEFT  = 6;
  localparam int A_HIMG   = 7;
  localparam int A_HFRONT = 8;
  localparam int A_HIRQ   = 9;
  localparam int A_VIRQ   = 10;
  localparam int A_VSYNC  = 11;
  localparam int A_SOFF   = 12;
  localparam int A_BCOL   = 13;
  localparam int A_HNOW   = 14;
  localparam int A_VNOW   = 15;
endpackage

// File: rtl/lcd_tc_regs.sv
module lcd_tc_regs
  import lcd_tc_pkg::*;
#(
  parameter int CW = 12,
  parameter int AW = 4,
  parameter int DW = 32,
  parameter int COLW = 24
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [DW-1:0]             wdata_i,
  output logic [DW-1:0]             rdata_o,
  input  logic [CW-1:0]             hcnt_i,
  input  logic [CW-1:0]             vcnt_i,
  input  logic                      h_set_i,
  input  logic                      v_set_i,
  output logic                      en_o,
  output logic                      hmask_o,
  output logic                      vmask_o,
  output logic [CW-1:0]             hlast_o,
  output logic [CW-1:0]             vlast_o,
  output logic [N_EVT-1:0][CW-1:0]  thr_o,
  output logic [CW-1:0]             hirq_on_o,
  output logic [CW-1:0]             hirq_off_o,
  output logic [CW-1:0]             virq_on_o,
  output logic [CW-1:0]             virq_off_o,
  output logic [CW-1:0]             vs_on_o,
  output logic [CW-1:0]             vs_off_o,
  output logic                      hoff_o,
  output logic                      voff_o,
  output logic [COLW-1:0]           bcol_o,
  output logic                      hpend_o,
  output logic                      vpend_o
);
  localparam int HI = 16;

  logic wr_stat;
  assign wr_stat = wr_en_i && (addr_i == AW'(A_STAT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o <= 1'b0; hmask_o <= 1'b0; vmask_o <= 1'b0;
      hlast_o <= '0; vlast_o <= '0; thr_o <= '0;
      hirq_on_o <= '0; hirq_off_o <= '0; virq_on_o <= '0; virq_off_o <= '0;
      vs_on_o <= '0; vs_off_o <= '0; hoff_o <= 1'b0; voff_o <= 1'b0;
      bcol_o <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        AW'(A_CTRL):   begin en_o <= wdata_i[0]; hmask_o <= wdata_i[8]; vmask_o <= wdata_i[9]; end
        AW'(A_HLAST):  hlast_o <= wdata_i[CW-1:0];
        AW'(A_VLAST):  vlast_o <= wdata_i[CW-1:0];
        AW'(A_HSYNC):  thr_o[PH_SYNC]  <= wdata_i[CW-1:0];
        AW'(A_HBACK):  thr_o[PH_BACK]  <= wdata_i[CW-1:0];
        AW'(A_HLEFT):  thr_o[PH_LEFT]  <= wdata_i[CW-1:0];
        AW'(A_HIMG):   begin thr_o[PH_IMAGE] <= wdata_i[CW-1:0]; thr_o[PH_RIGHT] <= wdata_i[HI +: CW]; end
        AW'(A_HFRONT): thr_o[PH_FRONT] <= wdata_i[CW-1:0];
        AW'(A_HIRQ):   begin hirq_on_o <= wdata_i[CW-1:0]; hirq_off_o <= wdata_i[HI +: CW]; end
        AW'(A_VIRQ):   begin virq_on_o <= wdata_i[CW-1:0]; virq_off_o <= wdata_i[HI +: CW]; end
        AW'(A_VSYNC):  begin vs_on_o <= wdata_i[CW-1:0]; vs_off_o <= wdata_i[HI +: CW]; end
        AW'(A_SOFF):   begin hoff_o <= wdata_i[0]; voff_o <= wdata_i[8]; end
        AW'(A_BCOL):   bcol_o <= wdata_i[COLW-1:0];
        default: ;
      endcase
    end
  end

  // set wins over a clearing write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hpend_o <= 1'b0;
      vpend_o <= 1'b0;
    end else begin
      hpend_o <= h_set_i | (hpend_o & ~(wr_stat & wdata_i[16]));
      vpend_o <= v_set_i | (vpend_o & ~(wr_stat & wdata_i[17]));
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      AW'(A_CTRL):   begin rdata_o[0] = en_o; rdata_o[8] = hmask_o; rdata_o[9] = vmask_o; end
      AW'(A_STAT):   begin rdata_o[16] = hpend_o; rdata_o[17] = vpend_o; end
      AW'(A_HLAST):  rdata_o[CW-1:0] = hlast_o;
      AW'(A_VLAST):  rdata_o[CW-1:0] = vlast_o;
      AW'(A_HSYNC):  rdata_o[CW-1:0] = thr_o[PH_SYNC];
      AW'(A_HBACK):  rdata_o[CW-1:0] = thr_o[PH_BACK];
      AW'(A_HLEFT):  rdata_o[CW-1:0] = thr_o[PH_LEFT];
      AW'(A_HIMG):   begin rdata_o[CW-1:0] = thr_o[PH_IMAGE]; rdata_o[HI +: CW] = thr_o[PH_RIGHT]; end
      AW'(A_HFRONT): rdata_o[CW-1:0] = thr_o[PH_FRONT];
      AW'(A_HIRQ):   begin rdata_o[CW-1:0] = hirq_on_o; rdata_o[HI +: CW] = hirq_off_o; end
      AW'(A_VIRQ):   begin rdata_o[CW-1:0] = virq_on_o; rdata_o[HI +: CW] = virq_off_o; end
      AW'(A_VSYNC):  begin rdata_o[CW-1:0] = vs_on_o; rdata_o[HI +: CW] = vs_off_o; end
      AW'(A_SOFF):   begin rdata_o[0] = hoff_o; rdata_o[8] = voff_o; end
      AW'(A_BCOL):   rdata_o[COLW-1:0] = bcol_o;
      AW'(A_HNOW):   rdata_o[CW-1:0] = hcnt_i;
      AW'(A_VNOW):   rdata_o[CW-1:0] = vcnt_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/lcd_tc_hline.sv
module lcd_tc_hline
  import lcd_tc_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic [CW-1:0]             hlast_i,
  input  logic [N_EVT-1:0][CW-1:0]  thr_i,
  input  logic [CW-1:0]             irq_on_i,
  input  logic [CW-1:0]             irq_off_i,
  output logic [CW-1:0]             hcnt_o,
  output logic                      line_end_o,
  output logic                      line_start_o,
  output phase_e                    phase_o,
  output logic                      win_o,
  output logic                      set_o
);
  logic [N_EVT-1:0] hit;
  phase_e           pick;
  logic             clr;

  for (genvar g = 0; g < N_EVT; g++) begin : g_cmp
    assign hit[g] = (thr_i[g] == hcnt_o);
  end

  // lowest index = highest priority
  always_comb begin
    pick = phase_o;
    for (int i = N_EVT - 1; i >= 0; i--) begin
      if (hit[i]) pick = phase_e'(3'(i));
    end
  end

  assign line_end_o   = en_i && (hcnt_o >= hlast_i);
  assign line_start_o = en_i && (hcnt_o == '0);
  assign set_o        = en_i && (hcnt_o == irq_on_i) && (irq_on_i < hlast_i);
  assign clr          = en_i && (hcnt_o == irq_off_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_o  <= '0;
      phase_o <= PH_FRONT;
      win_o   <= 1'b0;
    end else if (!en_i) begin
      hcnt_o  <= '0;
      phase_o <= PH_FRONT;
      win_o   <= 1'b0;
    end else begin
      hcnt_o  <= line_end_o ? '0 : hcnt_o + 1'b1;
      phase_o <= pick;
      if (set_o)    win_o <= 1'b1;
      else if (clr) win_o <= 1'b0;
    end
  end
endmodule

// File: rtl/lcd_tc_vframe.sv
module lcd_tc_vframe #(
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          line_end_i,
  input  logic          line_start_i,
  input  logic [CW-1:0] vlast_i,
  input  logic [CW-1:0] irq_on_i,
  input  logic [CW-1:0] irq_off_i,
  input  logic [CW-1:0] vs_on_i,
  input  logic [CW-1:0] vs_off_i,
  output logic [CW-1:0] vcnt_o,
  output logic          win_o,
  output logic          set_o,
  output logic          vs_o
);
  logic clr;

  assign set_o = line_start_i && (vcnt_o == irq_on_i) && (irq_on_i < vlast_i);
  assign clr   = line_start_i && (vcnt_o == irq_off_i);
  assign vs_o  = en_i && (vcnt_o >= vs_on_i) && (vcnt_o < vs_off_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vcnt_o <= '0;
      win_o  <= 1'b0;
    end else if (!en_i) begin
      vcnt_o <= '0;
      win_o  <= 1'b0;
    end else begin
      if (line_end_i) vcnt_o <= (vcnt_o >= vlast_i) ? '0 : vcnt_o + 1'b1;
      if (set_o)      win_o <= 1'b1;
      else if (clr)   win_o <= 1'b0;
    end
  end
endmodule

// File: rtl/lcd_timing_ctrl.sv
module lcd_timing_ctrl
  import lcd_tc_pkg::*;
#(
  parameter int CW   = 12,
  parameter int AW   = 4,
  parameter int DW   = 32,
  parameter int COLW = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            hsync_o,
  output logic            vsync_o,
  output logic            pix_en_o,
  output logic            border_sel_o,
  output logic [COLW-1:0] border_color_o,
  output logic            h_irq_o,
  output logic            v_irq_o
);
  logic                     en, hmask, vmask, hoff, voff, hpend, vpend;
  logic [CW-1:0]            hlast, vlast, hirq_on, hirq_off, virq_on, virq_off, vs_on, vs_off;
  logic [N_EVT-1:0][CW-1:0] thr;
  logic [COLW-1:0]          bcol;
  logic [CW-1:0]            hcnt, vcnt;
  logic                     line_end, line_start, hwin, h_set, vwin, v_set, vs_act;
  phase_e                   phase;

  lcd_tc_regs #(.CW(CW), .AW(AW), .DW(DW), .COLW(COLW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .hcnt_i(hcnt), .vcnt_i(vcnt), .h_set_i(h_set), .v_set_i(v_set),
    .en_o(en), .hmask_o(hmask), .vmask_o(vmask), .hlast_o(hlast), .vlast_o(vlast),
    .thr_o(thr), .hirq_on_o(hirq_on), .hirq_off_o(hirq_off),
    .virq_on_o(virq_on), .virq_off_o(virq_off), .vs_on_o(vs_on), .vs_off_o(vs_off),
    .hoff_o(hoff), .voff_o(voff), .bcol_o(bcol), .hpend_o(hpend), .vpend_o(vpend)
  );

  lcd_tc_hline #(.CW(CW)) u_hline (
    .clk_i, .rst_ni, .en_i(en), .hlast_i(hlast), .thr_i(thr),
    .irq_on_i(hirq_on), .irq_off_i(hirq_off),
    .hcnt_o(hcnt), .line_end_o(line_end), .line_start_o(line_start),
    .phase_o(phase), .win_o(hwin), .set_o(h_set)
  );

  lcd_tc_vframe #(.CW(CW)) u_vframe (
    .clk_i, .rst_ni, .en_i(en), .line_end_i(line_end), .line_start_i(line_start),
    .vlast_i(vlast), .irq_on_i(virq_on), .irq_off_i(virq_off),
    .vs_on_i(vs_on), .vs_off_i(vs_off),
    .vcnt_o(vcnt), .win_o(vwin), .set_o(v_set), .vs_o(vs_act)
  );

  assign hsync_o        = (phase == PH_SYNC) && !hoff;
  assign vsync_o        = vs_act && !voff;
  assign pix_en_o       = (phase == PH_IMAGE);
  assign border_sel_o   = (phase == PH_LEFT) || (phase == PH_RIGHT);
  assign border_color_o = border_sel_o ? bcol : '0;
  assign h_irq_o        = hwin && !hmask;
  assign v_irq_o        = vwin && !vmask;
endmodule

// File: rtl/lcd_tc_chk.sv
module lcd_tc_chk
  import lcd_tc_pkg::*;
#(
  parameter int CW = 12,
  parameter int AW = 4,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic [CW-1:0] hcnt_i,
  input logic [CW-1:0] hlast_i,
  input logic [CW-1:0] vcnt_i,
  input logic          line_end_i,
  input logic          vwin_i,
  input logic          hoff_i,
  input logic          h_set_i,
  input logic          hpend_i,
  input logic          wr_en_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic          hsync_o,
  input logic          pix_en_o,
  input logic          border_sel_o
);
  a_r1_hcnt_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && hcnt_i >= hlast_i) |=> (hcnt_i == '0));

  a_r4_pix_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_en_o |-> (!border_sel_o && !hsync_o));

  a_r6_vcnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !line_end_i) |=> (vcnt_i == $past(vcnt_i)));

  a_r7_vwin_at_line_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vwin_i) |-> ($past(hcnt_i) == '0));

  a_r8_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == AW'(A_STAT) && wdata_i[16] && !h_set_i) |=> !hpend_i);

  a_r9_hsync_suppressed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hoff_i |-> !hsync_o);

  a_r10_idle_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (hcnt_i == '0 && vcnt_i == '0 && !hsync_o && !pix_en_o && !border_sel_o));
endmodule

bind lcd_timing_ctrl lcd_tc_chk #(.CW(CW), .AW(AW), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en), .hcnt_i(hcnt), .hlast_i(hlast),
  .vcnt_i(vcnt), .line_end_i(line_end), .vwin_i(vwin), .hoff_i(hoff),
  .h_set_i(h_set), .hpend_i(hpend), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .hsync_o(hsync_o), .pix_en_o(pix_en_o), .border_sel_o(border_sel_o)
);

// File: tb/lcd_timing_ctrl_bench.sv
module lcd_timing_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  addr_i = 4'd0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        hsync_o, vsync_o, pix_en_o, border_sel_o, h_irq_o, v_irq_o;
  logic [23:0] border_color_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  lcd_timing_ctrl u_lcd_timing_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .hsync_o, .vsync_o, .pix_en_o, .border_sel_o, .border_color_o, .h_irq_o, .v_irq_o
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  // {hcount, hsync, pix_en, border_sel, h_irq} for one line of the base timing
  localparam logic [15:0] LINE_VEC [14] = '{
    {12'd0,  4'b0000}, {12'd1,  4'b1000}, {12'd2,  4'b1000}, {12'd3,  4'b0000},
    {12'd4,  4'b0001}, {12'd5,  4'b0011}, {12'd7,  4'b0101}, {12'd9,  4'b0101},
    {12'd10, 4'b0100}, {12'd14, 4'b0100}, {12'd15, 4'b0010}, {12'd16, 4'b0010},
    {12'd17, 4'b0000}, {12'd19, 4'b0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic wait_pos(input int v, input int h);
    logic [31:0] hv, vv;
    bit found = 1'b0;
    for (int n = 0; n < 1000 && !found; n++) begin
      @(negedge clk_i);
      rd(4'd15, vv);
      rd(4'd14, hv);
      if (hv == 32'(h) && (v < 0 || vv == 32'(v))) found = 1'b1;
    end
    if (!found) check("R1 position reached", 32'd0, 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    // R11 reset state
    rd(4'd14, d); check("R11 hcount after reset", d, 0);
    rd(4'd0, d);  check("R11 ctrl after reset", d, 0);
    check("R11 outputs after reset",
          {hsync_o, vsync_o, pix_en_o, border_sel_o, h_irq_o, v_irq_o, border_color_o}, 0);
    rst_ni = 1'b1;

    wr(4'd2, 19); wr(4'd3, 3);
    wr(4'd4, 0);  wr(4'd5, 2); wr(4'd6, 4);
    wr(4'd7, (14 << 16) | 6); wr(4'd8, 16);
    wr(4'd9, (9 << 16) | 3);  wr(4'd10, (3 << 16) | 2);
    wr(4'd11, (2 << 16) | 1); wr(4'd13, 32'h00A0B0C0);
    wr(4'd0, 1);

    // R2 R4 R5 phase walk over one line
    wait_pos(-1, 0);
    for (int i = 0; i < 14; i++) begin
      wait_pos(-1, int'(LINE_VEC[i][15:4]));
      check($sformatf("R2 R4 R5 line vector hc=%0d", LINE_VEC[i][15:4]),
            {hsync_o, pix_en_o, border_sel_o, h_irq_o}, LINE_VEC[i][3:0]);
    end

    // R1 wrap
    wait_pos(-1, 19);
    @(negedge clk_i); rd(4'd14, d); check("R1 hcount wraps to 0", d, 0);

    // R6 vertical counter and vsync window
    wait_pos(3, 19);
    @(negedge clk_i); rd(4'd15, d); check("R6 vcount wraps to 0", d, 0);
    wait_pos(1, 0);  check("R6 vsync on line 1", vsync_o, 1);
    wait_pos(2, 0);  check("R6 vsync off line 2", vsync_o, 0);

    // R7 V interrupt opens on line 2 after hcount 0
    wait_pos(2, 1);  check("R7 v_irq open", v_irq_o, 1);
    wait_pos(3, 0);  check("R7 v_irq still open at h0", v_irq_o, 1);
    wait_pos(3, 1);  check("R7 v_irq closed", v_irq_o, 0);

    // R8 pending and W1C
    rd(4'd1, d); check("R8 V pending set", d[17], 1);
    wr(4'd1, 32'h0002_0000);
    rd(4'd1, d); check("R8 V pending cleared by W1C", d[17], 0);

    // R8 masks
    wr(4'd0, 32'h301);
    wait_pos(2, 5);
    check("R8 v_irq masked", v_irq_o, 0);
    rd(4'd1, d); check("R8 V pending set while masked", d[17], 1);
    wait_pos(-1, 6);
    check("R8 h_irq masked", h_irq_o, 0);
    rd(4'd1, d); check("R8 H pending set while masked", d[16], 1);
    wr(4'd0, 1);

    // R5 assert count at H_LAST disables
    wr(4'd9, (19 << 16) | 19);
    wr(4'd1, 32'h0003_0000);
    wait_pos(-1, 2);
    wait_pos(-1, 1);
    rd(4'd1, d); check("R5 H pending stays clear when disabled", d[16], 0);
    wait_pos(-1, 10); check("R5 h_irq never opens", h_irq_o, 0);
    wr(4'd9, (9 << 16) | 3);

    // R3 left border and image start collide: left border wins
    wr(4'd6, 6);
    wait_pos(-1, 0);
    wait_pos(-1, 8);  check("R3 collision pix_en", pix_en_o, 0);
    check("R3 collision border_sel", border_sel_o, 1);
    wait_pos(-1, 14); check("R3 collision held to image end", {pix_en_o, border_sel_o}, 2'b01);
    wr(4'd6, 4);

    // R4 border color
    wr(4'd13, 32'hAABBCCDD);
    rd(4'd13, d); check("R4 border color top byte dropped", d, 32'h00BBCCDD);
    wait_pos(-1, 0);
    wait_pos(-1, 5); check("R4 border color in left border", border_color_o, 24'hBBCCDD);
    wait_pos(-1, 7); check("R4 border color zero in image", border_color_o, 0);
    wait_pos(-1, 15); check("R4 border color in right border", border_color_o, 24'hBBCCDD);

    // R9 sync suppress
    wr(4'd12, 32'h101);
    wait_pos(-1, 1); check("R9 hsync suppressed", hsync_o, 0);
    wait_pos(1, 3);  check("R9 vsync suppressed", vsync_o, 0);
    wr(4'd12, 0);
    wait_pos(1, 1);  check("R9 hsync restored", hsync_o, 1);

    // R10 stop
    wait_pos(2, 8);
    wr(4'd0, 0);
    @(negedge clk_i);
    rd(4'd14, d); check("R10 hcount held 0", d, 0);
    rd(4'd15, d); check("R10 vcount held 0", d, 0);
    check("R10 outputs inactive",
          {hsync_o, vsync_o, pix_en_o, border_sel_o, h_irq_o, v_irq_o}, 0);
    repeat (30) @(negedge clk_i);
    rd(4'd14, d); check("R10 hcount still 0", d, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule